// File: doc/BRIEF.md
# Zone-Weighted Luminance Meter

This block measures the brightness of a video frame for an exposure loop. It watches a pixel-rate luminance stream qualified by a line-valid and a frame-valid strobe. It places every pixel in a rectangular zone of a square grid, where each zone is 44 pixels wide and 36 lines tall by default, so a 352 x 288 frame fills an 8 x 8 grid. Each zone carries a weight in quarter steps, taken from one of four maps that a 2-bit window select picks. The block sums weight times luminance over the frame and divides by the sum of the weights. The output is a 12-bit meter value: the mean luminance with four extra fraction bits.

The sums clear when a frame starts. When a frame ends, the totals are copied into a bit-serial divider, and the meter register is written only once the division completes. A reader therefore always sees the result of a whole frame. The window select is sampled once, at the start of each frame.

Top module: `zone_luma_meter`

## Requirements
- R1: After reset, meter_lo and meter_hi are both 0.
- R2: A counted pixel at column x and line y of its frame (both counted from 0) belongs to zone column x/ZONE_W and zone row y/ZONE_H, using integer division. Pixels whose zone column or zone row is GRID or more do not change the result.
- R3: win_mode 0 (center map one) gives weight 5/4 to zones whose row and column both lie in GRID/4 .. GRID-1-GRID/4, and 2/4 to the four corner zones. All other zones get 1.
- R4: win_mode 1 (center map two) gives 5/4 to the same central block and 2/4 to the rest of zone row 0. The remaining outer-rim zones get 1, and every other zone gets 3/4.
- R5: win_mode 2 (no window) gives weight 1 to every zone.
- R6: win_mode 3 (lower weighted) gives 2/4 to zone rows below GRID/4, 1 to rows below GRID/2, and 5/4 to all lower rows.
- R7: The meter value is floor(16·Σ(w·Y)/Σw) over all counted pixels, with the weights w in quarters. It is presented as bits 7:0 on meter_lo and bits 11:8 on meter_hi, so the value never exceeds 4080.
- R8: A frame that contains no counted pixel yields a meter value of 0.
- R9: win_mode is sampled in the cycle frame_valid rises. A change of win_mode later in the same frame has no effect on that frame's result.
- R10: The meter changes only in the 12th cycle after the cycle in which frame_valid is first seen low. It holds that value throughout the next frame.
- R11: The sums clear when a frame starts. Two frames separated by a single low cycle of frame_valid are each measured on their own.
- R12: A pixel is counted only when frame_valid and line_valid are both high. Luminance on any other cycle, including line_valid pulses while frame_valid is low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | High for the duration of a frame |
| line_valid | input | 1 | High while the pixels of a line are present |
| luma | input | LUMA_W | Pixel luminance |
| win_mode | input | 2 | Weight map select (0 center one, 1 center two, 2 uniform, 3 lower) |
| meter_lo | output | 8 | Meter value, bits 7:0 |
| meter_hi | output | LUMA_W-4 | Meter value, bits 11:8 |

## Verification
Two activities can overlap in time. The divider may still be working on the totals of a finished frame while the sums are being cleared and refilled by the next frame. The bench provokes this by starting a new frame after only one low cycle of frame_valid. It judges the overlap by reading, in the middle of the second frame, exactly the first frame's expected value, and after the second frame its own independently computed value. Random images under all four maps, with a mode change in mid-frame and pixels outside the grid, are compared against a bench model of the weight maps and the division.

// File: rtl/zone_luma_meter.sv
module zone_luma_meter #(
  parameter int LUMA_W = 8,
  parameter int ZONE_W = 44,
  parameter int ZONE_H = 36,
  parameter int GRID   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic              line_valid,
  input  logic [LUMA_W-1:0] luma,
  input  logic [1:0]        win_mode,
  output logic [7:0]        meter_lo,
  output logic [LUMA_W-5:0] meter_hi
);

  localparam int FRAC    = 4;
  localparam int OUT_W   = LUMA_W + FRAC;
  localparam int MAXY    = (1 << LUMA_W) - 1;
  localparam int PIX_MAX = GRID * GRID * ZONE_W * ZONE_H;
  localparam int W_W     = $clog2(PIX_MAX * 5 + 1);
  localparam int ACC_W   = $clog2(PIX_MAX * 5 * MAXY + 1);
  localparam int R_W     = ACC_W + OUT_W;
  localparam int P_W     = LUMA_W + 3;
  localparam int CX_W    = $clog2(ZONE_W);
  localparam int CY_W    = $clog2(ZONE_H);
  localparam int Z_W     = $clog2(GRID + 1);
  localparam int S_W     = $clog2(OUT_W);
  localparam int C_LO    = GRID / 4;
  localparam int C_HI    = GRID - 1 - GRID / 4;

  logic             fv_d, lv_d;
  logic [1:0]       mode_q;
  logic [CX_W-1:0]  cx;
  logic [CY_W-1:0]  cy;
  logic [Z_W-1:0]   zc, zr;
  logic [ACC_W-1:0] acc;
  logic [W_W-1:0]   wsum;
  logic             busy;
  logic [S_W-1:0]   step;
  logic [R_W-1:0]   rem;
  logic [W_W-1:0]   den;
  logic [OUT_W-1:0] quo, meter;
  logic [2:0]       wq;
  logic [P_W-1:0]   prod;

  wire fstart  = frame_valid & ~fv_d;
  wire fend    = ~frame_valid & fv_d;
  wire pix     = frame_valid & line_valid;
  wire lend    = frame_valid & lv_d & ~line_valid;
  wire in_grid = (zc < Z_W'(GRID)) && (zr < Z_W'(GRID));
  wire take    = pix & in_grid;
  wire [1:0] cur_mode = fstart ? win_mode : mode_q;

  function automatic logic [2:0] zone_wt(input logic [1:0] m, input int r, input int c);
    logic ctr, corner, rim;
    ctr    = (r >= C_LO) && (r <= C_HI) && (c >= C_LO) && (c <= C_HI);
    corner = (r == 0 || r == GRID - 1) && (c == 0 || c == GRID - 1);
    rim    = (r == 0) || (r == GRID - 1) || (c == 0) || (c == GRID - 1);
    case (m)
      2'd0:    zone_wt = ctr ? 3'd5 : (corner ? 3'd2 : 3'd4);
      2'd1:    zone_wt = ctr ? 3'd5 : (r == 0) ? 3'd2 : (rim ? 3'd4 : 3'd3);
      2'd2:    zone_wt = 3'd4;
      default: zone_wt = (r < GRID / 4) ? 3'd2 : (r < GRID / 2) ? 3'd4 : 3'd5;
    endcase
  endfunction

  assign wq = zone_wt(cur_mode, int'(zr), int'(zc));

  always_comb begin
    case (wq)
      3'd2:    prod = P_W'(luma) << 1;
      3'd3:    prod = (P_W'(luma) << 1) + P_W'(luma);
      3'd4:    prod = P_W'(luma) << 2;
      3'd5:    prod = (P_W'(luma) << 2) + P_W'(luma);
      default: prod = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_d <= 1'b0;
      lv_d <= 1'b0;
      mode_q <= 2'd0;
    end else begin
      fv_d <= frame_valid;
      lv_d <= line_valid;
      if (fstart) mode_q <= win_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !line_valid) begin
      cx <= '0;
      zc <= '0;
    end else if (pix) begin
      if (cx == CX_W'(ZONE_W - 1)) begin
        cx <= '0;
        if (zc < Z_W'(GRID)) zc <= zc + 1'b1;
      end else begin
        cx <= cx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !frame_valid) begin
      cy <= '0;
      zr <= '0;
    end else if (lend) begin
      if (cy == CY_W'(ZONE_H - 1)) begin
        cy <= '0;
        if (zr < Z_W'(GRID)) zr <= zr + 1'b1;
      end else begin
        cy <= cy + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      wsum <= '0;
    end else if (fstart) begin
      acc  <= take ? ACC_W'(prod) : '0;
      wsum <= take ? W_W'(wq) : '0;
    end else if (take) begin
      acc  <= acc + ACC_W'(prod);
      wsum <= wsum + W_W'(wq);
    end
  end

  wire [R_W-1:0]   trial  = R_W'(den) << step;
  wire             fits   = rem >= trial;
  wire [OUT_W-1:0] quo_nx = fits ? (quo | (OUT_W'(1) << step)) : quo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      rem   <= '0;
      den   <= '0;
      quo   <= '0;
      meter <= '0;
    end else if (fend) begin
      if (wsum == '0) begin
        busy <= 1'b1;
        den  <= '1;
        rem  <= '0;
      end else begin
        busy <= 1'b1;
        den  <= wsum;
        rem  <= R_W'(acc) << FRAC;
      end
      step <= S_W'(OUT_W - 1);
      quo  <= '0;
    end else if (busy) begin
      quo <= quo_nx;
      if (fits) rem <= rem - trial;
      if (step == '0) begin
        busy  <= 1'b0;
        meter <= quo_nx;
      end else begin
        step <= step - 1'b1;
      end
    end
  end

  assign meter_lo = meter[7:0];
  assign meter_hi = meter[OUT_W-1:8];

  a_r2_outside_grid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pix && !fstart && !in_grid) |=> $stable(acc));
  a_r7_meter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    meter <= OUT_W'(MAXY << FRAC));
  a_r7_sum_vs_weights: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACC_W'(wsum) * ACC_W'(MAXY));
  a_r10_meter_only_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(meter));
  a_r10_full_division: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(step) == '0);
  a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |=> acc <= ACC_W'(5 * MAXY));

endmodule

// File: tb/tb_zone_luma_meter.sv
module tb_zone_luma_meter;
  localparam int ZW = 3;
  localparam int ZH = 2;
  localparam int G  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_valid = 1'b0;
  logic       line_valid = 1'b0;
  logic [7:0] luma = 8'd0;
  logic [1:0] win_mode = 2'd0;
  logic [7:0] meter_lo;
  logic [3:0] meter_hi;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] img [0:19][0:29];

  always #4 clk = ~clk;

  zone_luma_meter #(.LUMA_W(8), .ZONE_W(ZW), .ZONE_H(ZH), .GRID(G)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .line_valid(line_valid),
    .luma(luma), .win_mode(win_mode), .meter_lo(meter_lo), .meter_hi(meter_hi));

  function automatic int wt_of(int m, int r, int c);
    bit ctr = (r >= 2 && r <= 5 && c >= 2 && c <= 5);
    if (m == 0) return ctr ? 5 : ((r == 0 || r == 7) && (c == 0 || c == 7)) ? 2 : 4;
    if (m == 1) return ctr ? 5 : (r == 0) ? 2 : (r == 7 || c == 0 || c == 7) ? 4 : 3;
    if (m == 2) return 4;
    return (r < 2) ? 2 : (r < 4) ? 4 : 5;
  endfunction

  function automatic int expect_val(int m, int w, int h);
    longint a = 0;
    longint s = 0;
    for (int l = 0; l < h; l++)
      for (int c = 0; c < w; c++)
        if (c < ZW * G && l < ZH * G) begin
          int k = wt_of(m, l / ZH, c / ZW);
          a += k * img[l][c];
          s += k;
        end
    return (s == 0) ? 0 : int'((a * 16) / s);
  endfunction

  function automatic int meter_now();
    return {meter_hi, meter_lo};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int l = 0; l < 20; l++)
      for (int c = 0; c < 30; c++) img[l][c] = 8'($urandom);
  endtask

  task automatic run_frame(int m, int w, int h, bit flip_mode);
    @(negedge clk);
    frame_valid = 1'b1;
    win_mode = 2'(m);
    for (int l = 0; l < h; l++) begin
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        line_valid = 1'b1;
        luma = img[l][c];
        if (flip_mode && l == 1 && c == 0) win_mode = ~2'(m);
      end
      @(negedge clk);
      line_valid = 1'b0;
      luma = 8'($urandom);
      @(negedge clk);
      luma = 8'($urandom);
    end
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic frame_and_check(string req, int m, int w, int h, bit flip_mode);
    int e;
    run_frame(m, w, h, flip_mode);
    e = expect_val(m, w, h);
    repeat (16) @(negedge clk);
    check(req, meter_now(), e);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int e1, e2, prev;
    void'($urandom(20240611));
    repeat (4) @(negedge clk);
    check("R1 reset", meter_now(), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int l = 0; l < 20; l++)
      for (int c = 0; c < 30; c++) img[l][c] = 8'd255;
    frame_and_check("R7 full scale", 2, 24, 16, 0);
    check("R7 hi field", int'(meter_hi), 15);
    check("R7 lo field", int'(meter_lo), 240);

    for (int l = 0; l < 20; l++)
      for (int c = 0; c < 30; c++) img[l][c] = (c >= 24 || l >= 16) ? 8'd255 : 8'd16;
    frame_and_check("R2 beyond grid ignored", 0, 28, 19, 0);

    for (int l = 0; l < 20; l++)
      for (int c = 0; c < 30; c++)
        img[l][c] = (c < 3 && l < 2) ? 8'd200 : (l >= 8 && c >= 9 && c < 12) ? 8'd250 : 8'd40;
    frame_and_check("R3 corner/center map", 0, 24, 16, 0);
    frame_and_check("R4 second center map", 1, 24, 16, 0);
    frame_and_check("R5 uniform map", 2, 24, 16, 0);
    frame_and_check("R6 lower map", 3, 24, 16, 0);

    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 2; k++) begin
        fill_random();
        case (m)
          0: frame_and_check("R3 random", m, 20 + int'($urandom % 9), 12 + int'($urandom % 7), 0);
          1: frame_and_check("R4 random", m, 20 + int'($urandom % 9), 12 + int'($urandom % 7), 0);
          2: frame_and_check("R5 random", m, 20 + int'($urandom % 9), 12 + int'($urandom % 7), 0);
          default: frame_and_check("R6 random", m, 20 + int'($urandom % 9), 12 + int'($urandom % 7), 0);
        endcase
      end

    fill_random();
    frame_and_check("R9 mid-frame mode change", 3, 24, 16, 1);

    frame_and_check("R8 empty frame", 1, 24, 0, 0);

    fill_random();
    @(negedge clk);
    line_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      luma = 8'd255;
      @(negedge clk);
    end
    line_valid = 1'b0;
    frame_and_check("R12 strobes outside frame", 2, 24, 16, 0);

    prev = meter_now();
    fill_random();
    e1 = expect_val(0, 24, 16);
    run_frame(0, 24, 16, 0);
    repeat (6) @(negedge clk);
    check("R10 no early update", meter_now(), prev);
    repeat (10) @(negedge clk);
    check("R10 updated", meter_now(), e1);

    fill_random();
    e1 = expect_val(1, 24, 16);
    run_frame(1, 24, 16, 0);
    for (int l = 0; l < 20; l++)
      for (int c = 0; c < 30; c++) img[l][c] = 8'd255 - img[l][c];
    e2 = expect_val(3, 26, 16);
    fork
      run_frame(3, 26, 16, 0);
      begin
        repeat (40) @(negedge clk);
        check("R11 first of back-to-back", meter_now(), e1);
        check("R10 holds during next frame", meter_now(), e1);
      end
    join
    repeat (16) @(negedge clk);
    check("R11 second of back-to-back", meter_now(), e2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule